// File: doc/BRIEF.md
# Biased-Offset Program Counter

This block holds the instruction address of a small pipelined 8-bit processor. On every clock it takes a signed offset code from the control sequencer. It moves the address by that offset less a fixed bias of two. Because of the bias, code 2 holds the address, code 3 steps to the next byte, and the codes below 2 walk back to undo prefetches already in the pipeline. Branch displacements produced by the assembler already carry the same bias, so the sequencer passes them through unchanged.

A load strobe with an absolute address takes priority over the offset path for that cycle. Jumps, interrupt vectors and returns use this path. An asynchronous active-low reset places the counter at a parameterised reset vector. The sum can be built as one folded three-operand add or as an add followed by a bias subtraction, chosen by a parameter. Both forms give the same result.

Top module: `pc_offset_unit`

## Requirements
- R1: While `rst_n` is low the counter output equals the reset vector parameter `RESET_VEC` (default 16'h0100). It keeps that value on the first clock after release when a hold code is applied.
- R2: With `ld_en` low, the value after a rising edge is the previous value plus the offset code sign-extended to 16 bits, minus 2, modulo 2^16.
- R3: Offset code 8'h02 leaves the counter unchanged.
- R4: Offset code 8'h03 increases the counter by exactly one.
- R5: Offset code 8'h00 moves the counter back by two.
- R6: Offset code 8'hFF moves the counter back by three, returning it to the address that would have come next behind two pipeline stages.
- R7: Bit 7 of the offset code is the sign and is copied into bits 15 to 8. Code 8'h7F adds 125 and code 8'h80 subtracts 130.
- R8: The arithmetic wraps. Stepping forward past 16'hFFFF gives 16'h0000, and stepping back below 16'h0000 gives 16'hFFFF.
- R9: With `ld_en` high, the value after the edge equals `ld_addr`, whatever offset code is applied in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| off_code | input | 8 | Signed offset code from the sequencer, biased by two |
| ld_en | input | 1 | Absolute load strobe, overrides the offset |
| ld_addr | input | 16 | Absolute address loaded when `ld_en` is high |
| pc_q | output | 16 | Current program counter value |

## Verification
The absolute load and the offset arithmetic can both be requested in the same cycle. The bench provokes this by raising `ld_en` while it drives advance, rewind and large displacement codes. It then checks that the counter takes `ld_addr` exactly and that the offset has no effect. A behavioural model with wrap-around integer arithmetic is compared on every clock. The comparison covers reset, the named codes, both sign extremes, a wrap in each direction, and a long pseudo-random mix of loads and displacements.

// File: rtl/pc_unit_pkg.sv
package pc_unit_pkg;

   // How the biased sum is formed
   typedef enum logic {
      SUM_FOLDED   = 1'b0,   // one three-operand add with a folded constant
      SUM_TWO_STEP = 1'b1    // add offset, then subtract the bias
   } sum_style_e;

   // Named sequencer codes for the default 8-bit offset with bias two
   localparam logic [7:0] CODE_BACK3 = 8'hFF;
   localparam logic [7:0] CODE_BACK2 = 8'h00;
   localparam logic [7:0] CODE_HOLD  = 8'h02;
   localparam logic [7:0] CODE_STEP  = 8'h03;

endpackage

// File: rtl/pc_sext.sv
module pc_sext #(
   parameter int IN_W  = 8,
   parameter int OUT_W = 16
) (
   input  logic [IN_W-1:0]  raw,
   output logic [OUT_W-1:0] ext
);
   localparam int PAD_W = OUT_W - IN_W;

   generate
      if (PAD_W == 0) begin : g_same
         assign ext = raw;
      end else begin : g_pad
         assign ext = {{PAD_W{raw[IN_W-1]}}, raw};
      end
   endgenerate
endmodule

// File: rtl/pc_biased_adder.sv
module pc_biased_adder
   import pc_unit_pkg::*;
#(
   parameter int         W     = 16,
   parameter int         BIAS  = 2,
   parameter sum_style_e STYLE = SUM_FOLDED
) (
   input  logic [W-1:0] cur,
   input  logic [W-1:0] disp,
   output logic [W-1:0] nxt
);
   localparam logic [W-1:0] BIAS_V = W'(BIAS);
   // two's-complement negative of the bias, folded at elaboration
   localparam logic [W-1:0] NEG_BIAS = ~BIAS_V + W'(1);

   generate
      if (STYLE == SUM_FOLDED) begin : g_folded
         assign nxt = cur + disp + NEG_BIAS;
      end else begin : g_two_step
         logic [W-1:0] partial;
         assign partial = cur + disp;
         assign nxt     = partial - BIAS_V;
      end
   endgenerate
endmodule

// File: rtl/pc_reg.sv
module pc_reg #(
   parameter int           W     = 16,
   parameter logic [W-1:0] RST_V = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST_V;
      else        q <= d;
   end
endmodule

// File: rtl/pc_offset_unit.sv
module pc_offset_unit
   import pc_unit_pkg::*;
#(
   parameter int                ADDR_W    = 16,
   parameter int                OFF_W     = 8,
   parameter int                BIAS      = 2,
   parameter logic [ADDR_W-1:0] RESET_VEC = 16'h0100,
   parameter sum_style_e        SUM_STYLE = SUM_FOLDED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [OFF_W-1:0]  off_code,
   input  logic              ld_en,
   input  logic [ADDR_W-1:0] ld_addr,
   output logic [ADDR_W-1:0] pc_q
);
   localparam int MAX_POS = (1 << (OFF_W - 1)) - 1;

   // elaboration-time parameter checks
   generate
      if (OFF_W < 2) begin : g_bad_off
         $error("pc_offset_unit: OFF_W must be at least 2");
      end
      if (ADDR_W < OFF_W) begin : g_bad_addr
         $error("pc_offset_unit: ADDR_W must not be narrower than OFF_W");
      end
      if (BIAS < 0 || BIAS > MAX_POS) begin : g_bad_bias
         $error("pc_offset_unit: BIAS out of positive offset range");
      end
   endgenerate

   logic [ADDR_W-1:0] disp;
   logic [ADDR_W-1:0] sum;
   logic [ADDR_W-1:0] pc_d;

   pc_sext #(.IN_W(OFF_W), .OUT_W(ADDR_W)) u_sext (
      .raw (off_code),
      .ext (disp)
   );

   pc_biased_adder #(.W(ADDR_W), .BIAS(BIAS), .STYLE(SUM_STYLE)) u_add (
      .cur  (pc_q),
      .disp (disp),
      .nxt  (sum)
   );

   // absolute load wins over the offset path
   always_comb begin
      if (ld_en) pc_d = ld_addr;
      else       pc_d = sum;
   end

   pc_reg #(.W(ADDR_W), .RST_V(RESET_VEC)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pc_d),
      .q     (pc_q)
   );
endmodule

// File: rtl/pc_offset_unit_chk.sv
module pc_offset_unit_chk #(
   parameter int                ADDR_W    = 16,
   parameter int                OFF_W     = 8,
   parameter int                BIAS      = 2,
   parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic [OFF_W-1:0]  off_code,
   input logic              ld_en,
   input logic [ADDR_W-1:0] ld_addr,
   input logic [ADDR_W-1:0] pc_q
);
   logic [ADDR_W-1:0] wide_off;
   assign wide_off = {{(ADDR_W-OFF_W){off_code[OFF_W-1]}}, off_code};

   // R1
   reset_vec_chk: assert property (@(posedge clk)
      !rst_n |=> pc_q == RESET_VEC);

   // R2
   offset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_en |=> pc_q == ADDR_W'($past(pc_q) + $past(wide_off) - ADDR_W'(BIAS)));

   // R3
   hold_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && off_code == OFF_W'(BIAS)) |=> $stable(pc_q));

   // R4
   step_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && off_code == OFF_W'(BIAS + 1)) |=> pc_q == ADDR_W'($past(pc_q) + ADDR_W'(1)));

   // R6
   back3_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ld_en && off_code == '1) |=> pc_q == ADDR_W'($past(pc_q) - ADDR_W'(BIAS + 1)));

   // R9
   load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_en |=> pc_q == $past(ld_addr));
endmodule

bind pc_offset_unit pc_offset_unit_chk #(
   .ADDR_W    (ADDR_W),
   .OFF_W     (OFF_W),
   .BIAS      (BIAS),
   .RESET_VEC (RESET_VEC)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .off_code (off_code),
   .ld_en    (ld_en),
   .ld_addr  (ld_addr),
   .pc_q     (pc_q)
);

// File: tb/tb_pc_offset_unit.sv
module tb_pc_offset_unit;
   localparam int CLK_PERIOD = 10;
   localparam logic [15:0] RVEC = 16'h0100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  off_code = 8'h02;
   logic        ld_en = 1'b0;
   logic [15:0] ld_addr = 16'h0000;
   logic [15:0] pc_q;

   int total = 0;
   int bad = 0;
   int model = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pc_offset_unit #(.RESET_VEC(RVEC)) dut (
      .clk      (clk),
      .rst_n    (rst_n),
      .off_code (off_code),
      .ld_en    (ld_en),
      .ld_addr  (ld_addr),
      .pc_q     (pc_q)
   );

   task automatic check(input string tag);
      total++;
      if (pc_q !== model[15:0]) begin
         bad++;
         $display("FAIL %s: pc=%h expected=%h", tag, pc_q, model[15:0]);
      end
   endtask

   // drive at a falling edge, apply one rising edge, compare at next falling edge
   task automatic step(input logic [7:0] o, input logic ld, input logic [15:0] a,
                       input string tag);
      int s;
      off_code = o;
      ld_en    = ld;
      ld_addr  = a;
      @(posedge clk);
      s = o[7] ? int'(o) - 256 : int'(o);
      if (ld) model = int'(a);
      else    model = (model + s - 2) & 32'h0000FFFF;
      @(negedge clk);
      check(tag);
   endtask

   initial begin
      int wd = 0;
      while (!done && wd < 100000) begin
         @(posedge clk);
         wd++;
      end
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: cycles=%0d expected=finish", wd);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      model = int'(RVEC);
      repeat (3) @(negedge clk);
      check("R1 in reset");
      rst_n = 1'b1;
      step(8'h02, 1'b0, 16'h0000, "R1 first cycle after release");

      step(8'h02, 1'b0, 16'h0000, "R3 hold");
      step(8'h02, 1'b0, 16'h0000, "R3 hold again");
      step(8'h03, 1'b0, 16'h0000, "R4 advance");
      step(8'h03, 1'b0, 16'h0000, "R4 advance again");
      step(8'h00, 1'b0, 16'h0000, "R5 back two");
      step(8'hFF, 1'b0, 16'h0000, "R6 back three");
      step(8'h7F, 1'b0, 16'h0000, "R7 max positive");
      step(8'h80, 1'b0, 16'h0000, "R7 max negative");
      step(8'h10, 1'b0, 16'h0000, "R2 forward displacement");
      step(8'hF0, 1'b0, 16'h0000, "R2 backward displacement");

      step(8'h02, 1'b1, 16'hFFFE, "R9 load near top");
      step(8'h03, 1'b0, 16'h0000, "R8 step to FFFF");
      step(8'h03, 1'b0, 16'h0000, "R8 wrap to 0000");
      step(8'h7F, 1'b1, 16'h0001, "R9 load beats large offset");
      step(8'h00, 1'b0, 16'h0000, "R8 wrap below zero");
      step(8'h03, 1'b1, 16'h1234, "R9 load beats advance");
      step(8'hFF, 1'b1, 16'h4321, "R9 load beats rewind");
      step(8'h80, 1'b1, 16'h8000, "R9 load beats negative");
      step(8'h80, 1'b0, 16'h0000, "R7 negative from 8000");

      // asynchronous reset mid-run
      rst_n = 1'b0;
      #1;
      model = int'(RVEC);
      check("R1 async reset");
      @(negedge clk);
      check("R1 held in reset");
      rst_n = 1'b1;
      step(8'h02, 1'b0, 16'h0000, "R1 hold after release");

      for (int i = 0; i < 400; i++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[7:0], (lfsr[11:8] == 4'h5), {lfsr[3:0], lfsr[15:4]},
              "R2 mixed sequence");
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule